// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings for a clock synthesizer: a 9-bit loop divider value, a 3-bit output divider code and a 2-bit test select. The settings come from one of two sources. One is a set of parallel pins, which the block follows while the parallel strobe is low and freezes on its rising edge. The other is a 14-bit serial word, which is shifted in on serial clock edges and committed by a load strobe.

All control inputs are brought into one system clock domain through two-flop synchronizers. Edges on the serial clock, the load strobe and the parallel strobe are detected in that domain. A single test pin shows one of four internal signals. A flag reports when the active loop divider is outside the range over which the synthesizer can lock. The flagged value is still applied unchanged.

Top module: `divcfg_loader`

## Requirements
- R1: After the asynchronous active-low reset, with `par_load_n` high, `m_active` is 400, `n_active` is 0, both test-select bits are 0 (so `test_out` is low), and `m_out_of_range` is low.
- R2: While `par_load_n` is low (parallel mode), `m_active` and `n_active` follow `par_m` and `par_n` within four system clocks.
- R3: A rising edge of `par_load_n` freezes the last parallel values. Later changes on `par_m` and `par_n` have no effect on `m_active` and `n_active` while `par_load_n` stays high.
- R4: With `par_load_n` high, each rising edge of `ser_clk` shifts `ser_data` into a 14-bit shift register. While `ser_load` is low, shifting leaves `m_active`, `n_active` and the test bits unchanged.
- R5: A rising edge of `ser_load` copies the shift register into the active settings. The first bit shifted is test bit T1, then T0, then N2, N1, N0, then M8 down to M0, so the last bit shifted lands in M0.
- R6: After `ser_load` falls, further serial shifting does not change the active settings.
- R7: While `ser_load` stays high, every rising `ser_clk` edge also copies the newly shifted register contents into the active settings.
- R8: With `par_load_n` high, `test_out` depends on the test bits {T1,T0}:
  - 00 drives it low.
  - 01 drives it with the synchronized `ser_data`.
  - 10 drives it with `mfb_pulse`.
  - 11 drives it with `fout_sample`.
- R9: `test_out` is low whenever `par_load_n` is low, whatever the test bits are.
- R10: `m_out_of_range` is high exactly when `m_active` is below 250 or above 500. The out-of-range value still appears on `m_active`.
- R11: A serial load overrides values that were frozen from the parallel pins. Taking `par_load_n` low again returns control to the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit / transparency strobe |
| par_load_n | input | 1 | Low selects parallel mode; rising edge freezes pins |
| par_m | input | 9 | Parallel loop divider value |
| par_n | input | 3 | Parallel output divider code |
| mfb_pulse | input | 1 | Loop divider feedback pulse, observable on test pin |
| fout_sample | input | 1 | Output clock sample, observable on test pin |
| m_active | output | 9 | Active loop divider value |
| n_active | output | 3 | Active output divider code |
| test_out | output | 1 | Test multiplexer output |
| m_out_of_range | output | 1 | Loop divider outside 250..500 |

## Verification
The assertions check four things on every cycle. The settings follow the pins in parallel mode. The shift register advances by one bit on each detected serial clock edge. The load strobe edge copies the register into the active settings. The settings stay still when no load condition is present. They also check that the test pin stays low in parallel mode or with select 00. Only the bench scenarios show the full picture: the bit order of a complete 14-bit word, transparency across a whole shifted word, the boundary values of the range flag, and a serial load replacing values frozen from the pins.

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int M_W       = 9,
  parameter int N_W       = 3,
  parameter int M_DEFAULT = 400,
  parameter int N_DEFAULT = 0,
  parameter int M_MIN     = 250,
  parameter int M_MAX     = 500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           mfb_pulse,
  input  logic           fout_sample,
  output logic [M_W-1:0] m_active,
  output logic [N_W-1:0] n_active,
  output logic           test_out,
  output logic           m_out_of_range
);
  localparam int SR_W = M_W + N_W + 2;

  logic [1:0] sclk_q, sdat_q, sload_q, pload_q;
  logic       sclk_d, sload_d;
  logic [SR_W-1:0] sreg;
  logic [1:0]      t_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '0;
      sdat_q  <= '0;
      sload_q <= '0;
      pload_q <= 2'b11;
      sclk_d  <= 1'b0;
      sload_d <= 1'b0;
    end else begin
      sclk_q  <= {sclk_q[0], ser_clk};
      sdat_q  <= {sdat_q[0], ser_data};
      sload_q <= {sload_q[0], ser_load};
      pload_q <= {pload_q[0], par_load_n};
      sclk_d  <= sclk_q[1];
      sload_d <= sload_q[1];
    end
  end

  wire sclk_s     = sclk_q[1];
  wire sdat_s     = sdat_q[1];
  wire sload_s    = sload_q[1];
  wire pload_s    = pload_q[1];
  wire sclk_rise  = sclk_s & ~sclk_d;
  wire sload_rise = sload_s & ~sload_d;
  wire [SR_W-1:0] shifted = {sreg[SR_W-2:0], sdat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sreg <= '0;
    else if (pload_s && sclk_rise) sreg <= shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active <= M_W'(M_DEFAULT);
      n_active <= N_W'(N_DEFAULT);
      t_bits   <= 2'b00;
    end else if (!pload_s) begin
      m_active <= par_m;
      n_active <= par_n;
    end else if (sload_rise) begin
      {t_bits, n_active, m_active} <= sreg;
    end else if (sload_s && sclk_rise) begin
      {t_bits, n_active, m_active} <= shifted;
    end
  end

  always_comb begin
    unique case (t_bits)
      2'b00:   test_out = 1'b0;
      2'b01:   test_out = sdat_s;
      2'b10:   test_out = mfb_pulse;
      default: test_out = fout_sample;
    endcase
    if (!pload_s) test_out = 1'b0;
  end

  assign m_out_of_range = (int'(m_active) < M_MIN) || (int'(m_active) > M_MAX);
endmodule

module divcfg_loader_chk #(
  parameter int M_W  = 9,
  parameter int SR_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pload_s,
  input logic            sload_s,
  input logic            sload_rise,
  input logic            sclk_rise,
  input logic            sdat_s,
  input logic [SR_W-1:0] sreg,
  input logic [SR_W-1:0] cfg,
  input logic [M_W-1:0]  par_m,
  input logic [M_W-1:0]  m_active,
  input logic [1:0]      t_bits,
  input logic            test_out
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_s |=> m_active == $past(par_m)); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_s && sclk_rise) |=> sreg == {$past(sreg[SR_W-2:0]), $past(sdat_s)}); // R4
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_s && sload_rise) |=> cfg == $past(sreg)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_s && !sload_rise && !(sload_s && sclk_rise)) |=> $stable(cfg)); // R6
  AST_TEST_PAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_s |-> !test_out); // R9
  AST_TEST_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (t_bits == 2'b00) |-> !test_out); // R8
endmodule

bind divcfg_loader divcfg_loader_chk #(.M_W(M_W), .SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pload_s(pload_s), .sload_s(sload_s),
  .sload_rise(sload_rise), .sclk_rise(sclk_rise), .sdat_s(sdat_s),
  .sreg(sreg), .cfg({t_bits, n_active, m_active}), .par_m(par_m),
  .m_active(m_active), .t_bits(t_bits), .test_out(test_out)
);

// File: tb/test_divcfg_loader.sv
module test_divcfg_loader;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, par_load_n = 1;
  logic [8:0] par_m = '0;
  logic [2:0] par_n = '0;
  logic mfb_pulse = 0, fout_sample = 0;
  logic [8:0] m_active;
  logic [2:0] n_active;
  logic test_out, m_out_of_range;
  logic [13:0] mdl = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  divcfg_loader i_divcfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .mfb_pulse(mfb_pulse), .fout_sample(fout_sample), .m_active(m_active),
    .n_active(n_active), .test_out(test_out), .m_out_of_range(m_out_of_range));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] word(logic [1:0] t, logic [2:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic send_bit(logic b);
    ser_data = b; tick(2);
    ser_clk = 1; tick(4);
    mdl = {mdl[12:0], b};
    ser_clk = 0; tick(4);
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic commit();
    ser_load = 1; tick(4);
    ser_load = 0; tick(4);
  endtask

  task automatic t_reset();
    chk("R1 m", m_active, 400);
    chk("R1 n", n_active, 0);
    chk("R1 test", test_out, 0);
    chk("R1 flag", m_out_of_range, 0);
  endtask

  task automatic t_par_follow();
    par_load_n = 0; par_m = 300; par_n = 5; tick(4);
    chk("R2 m", m_active, 300); chk("R2 n", n_active, 5);
    par_m = 260; par_n = 2; tick(4);
    chk("R2 m2", m_active, 260); chk("R2 n2", n_active, 2);
  endtask

  task automatic t_par_hold();
    par_m = 320; par_n = 3; tick(4);
    par_load_n = 1; tick(4);
    par_m = 77; par_n = 6; tick(6);
    chk("R3 m", m_active, 320); chk("R3 n", n_active, 3);
  endtask

  task automatic t_serial();
    send_word(word(2'b01, 3'd6, 9'd450));
    chk("R4 m", m_active, 320); chk("R4 n", n_active, 3);
    ser_load = 1; tick(4);
    chk("R5 m", m_active, 450); chk("R5 n", n_active, 6);
    ser_load = 0; tick(4);
    ser_data = 1; tick(4); chk("R8 sel01 hi", test_out, 1);
    ser_data = 0; tick(4); chk("R8 sel01 lo", test_out, 0);
    send_word(word(2'b00, 3'd1, 9'd111));
    chk("R6 m", m_active, 450); chk("R6 n", n_active, 6);
  endtask

  task automatic t_transparent();
    ser_load = 1; tick(4);
    chk("R7 entry m", m_active, int'(mdl[8:0]));
    for (int i = 13; i >= 0; i--) begin
      send_bit(word(2'b00, 3'd2, 9'd270)[i]);
      chk("R7 m", m_active, int'(mdl[8:0]));
    end
    chk("R7 n", n_active, 2);
    ser_load = 0; tick(4);
  endtask

  task automatic t_test_sel();
    send_word(word(2'b10, 3'd0, 9'd300)); commit();
    mfb_pulse = 1; tick(1); chk("R8 sel10 hi", test_out, 1);
    mfb_pulse = 0; tick(1); chk("R8 sel10 lo", test_out, 0);
    send_word(word(2'b00, 3'd0, 9'd300)); commit();
    ser_data = 1; fout_sample = 1; mfb_pulse = 1; tick(4);
    chk("R8 sel00", test_out, 0);
    ser_data = 0; mfb_pulse = 0; fout_sample = 0;
    send_word(word(2'b11, 3'd0, 9'd300)); commit();
    fout_sample = 1; tick(1); chk("R8 sel11 hi", test_out, 1);
    fout_sample = 0; tick(1); chk("R8 sel11 lo", test_out, 0);
  endtask

  task automatic t_par_test_low();
    fout_sample = 1; tick(1); chk("R9 pre", test_out, 1);
    par_load_n = 0; tick(4); chk("R9 par low", test_out, 0);
    fout_sample = 0;
  endtask

  task automatic t_range();
    par_m = 249; tick(4); chk("R10 249", m_out_of_range, 1);
    par_m = 250; tick(4); chk("R10 250", m_out_of_range, 0);
    par_m = 500; tick(4); chk("R10 500", m_out_of_range, 0);
    par_m = 501; tick(4); chk("R10 501", m_out_of_range, 1);
    chk("R10 value kept", m_active, 501);
    par_load_n = 1; tick(4);
  endtask

  task automatic t_override();
    send_word(word(2'b00, 3'd4, 9'd333)); commit();
    chk("R11 serial m", m_active, 333); chk("R11 serial n", n_active, 4);
    par_m = 280; par_n = 7; par_load_n = 0; tick(4);
    chk("R11 pins m", m_active, 280); chk("R11 pins n", n_active, 7);
    par_load_n = 1; tick(4);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(4);
    t_reset();
    t_par_follow();
    t_par_hold();
    t_serial();
    t_transparent();
    t_test_sel();
    t_par_test_low();
    t_range();
    t_override();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule